// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory Copy Engine

The block copies a counted run of elements from one memory region to another on behalf of software. Four channels are programmed through a small word-addressed register port. Each channel holds a control word, a count word and three 64-bit addresses: source, destination and a descriptor pointer. Each address is written as two 32-bit halves. A single memory master port with a request/acknowledge handshake carries every data access.

Software loads the addresses and the count, then writes the channel's control word with the enable bit set. The engine queues the channel and, when it is idle, serves the lowest-numbered queued channel. Each element is moved with one read followed by one write. The element size is 1, 2, 4 or 8 bytes. The source and the destination may each advance or stay fixed.

When a channel's count is used up, the engine raises that channel's terminal-count flag in a shared status word. Software clears the flag by writing ones to it. The descriptor-pointer halves are plain storage and drive no behaviour.

Top module: `dma4_copy_engine`

## Requirements
- R1: Channel c owns register addresses 8*c to 8*c+7. The offsets hold, in order: control (0), count (1), source upper half (2), source lower half (3), destination upper half (4), destination lower half (5), descriptor upper half (6) and descriptor lower half (7). Every such register reads back its last written 32-bit value, and writing one half of an address leaves the other half unchanged.
- R2: Reads of address 0x20 to 0x3F other than 0x20 return zero, and writes to them change no register.
- R3: After reset every channel register and the status word read zero, and no memory request is raised.
- R4: A control write with bit 31 set, while the channel's count field is nonzero, starts a copy of exactly that many elements. Each element is one read (mem_we=0) followed by one write (mem_we=1), and each access waits for mem_ack.
- R5: The element count is count bits 15:0, and bits 31:16 are ignored. If the field is zero when enable is written, no memory access is made and no status bit is set.
- R6: Control bits 26:25 give field f, and an element is 1<<f bytes. mem_size carries f. Data is little-endian in the low 1<<f bytes of mem_rdata and mem_wdata.
- R7: Control bit 23 makes the source address advance by 1<<f bytes after each element, and control bit 24 does the same for the destination. When a bit is clear, that address stays fixed. The upper 32 address bits come from the upper-half registers.
- R8: When channel c finishes its count, status bit 31-c is set.
- R9: A write to the status word at address 0x20 clears every status bit that is 1 in the written value and keeps the other bits.
- R10: When several channels are queued, the lowest channel number is served first. A running copy is never interrupted.
- R11: While mem_req is high and mem_ack is low, mem_req, mem_we and mem_addr hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data (zero when reg_rd is low) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 64 | Byte address of the element |
| mem_size | output | 2 | Element size field, 1<<mem_size bytes |
| mem_wdata | output | 64 | Write data, little-endian in the low bytes |
| mem_ack | input | 1 | Access accepted and completed |
| mem_rdata | input | 64 | Read data, valid with mem_ack on a read |

## Verification
The embedded assertions check the following on every cycle:
- The request stays stable until it is acknowledged.
- An acknowledged read is followed by a write.
- At most one terminal-count pulse occurs per cycle.
- The arbiter picks only the lowest queued channel.
- Status writes clear the requested bits.
- Writes to unused addresses leave the state untouched.
- A zero count raises no request.

Only the bench scenarios can show the following:
- The copied bytes land where they should for every size and increment combination, including the last-element-wins effect of a fixed destination.
- The element count equals the programmed field.
- Flags are raised in priority order across channels queued behind a long copy.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  localparam int ADDR_W = 64;
  localparam int DATA_W = 64;
  localparam int REG_W  = 32;

  // Register offsets inside one channel's eight-word slot
  localparam logic [2:0] OFF_CTRL  = 3'd0;
  localparam logic [2:0] OFF_COUNT = 3'd1;
  localparam logic [2:0] OFF_SRC_H = 3'd2;
  localparam logic [2:0] OFF_SRC_L = 3'd3;
  localparam logic [2:0] OFF_DST_H = 3'd4;
  localparam logic [2:0] OFF_DST_L = 3'd5;

  // Control word fields
  localparam int CTL_EN    = 31;
  localparam int CTL_SZ_HI = 26;
  localparam int CTL_SZ_LO = 25;
  localparam int CTL_DINC  = 24;
  localparam int CTL_SINC  = 23;

  typedef enum logic [1:0] {
    MV_IDLE,
    MV_READ,
    MV_WRITE,
    MV_FINISH
  } mover_state_e;

  // Element size in bytes for a size field
  function automatic logic [ADDR_W-1:0] elem_bytes(input logic [1:0] f);
    return ADDR_W'(1) << f;
  endfunction

  // Address after one element
  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] f,
                                                  input logic inc);
    return inc ? (a + elem_bytes(f)) : a;
  endfunction

  // Byte-lane mask covering one element in the low bytes
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] f);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int b = 0; b < DATA_W / 8; b++) begin
      if (b < (1 << f)) m[b*8 +: 8] = 8'hFF;
    end
    return m;
  endfunction

endpackage

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int RAW = 6,
  parameter logic [RAW-1:0] STAT_ADDR = RAW'(32),
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [RAW-1:0]             reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  input  logic                       reg_wr,
  input  logic                       reg_rd,
  output logic [REG_W-1:0]           reg_rdata,
  input  logic [NCH-1:0]             tc_set,
  output logic [NCH-1:0]             start_req,
  output logic [NCH-1:0][15:0]       cfg_count,
  output logic [NCH-1:0][1:0]        cfg_size,
  output logic [NCH-1:0]             cfg_sinc,
  output logic [NCH-1:0]             cfg_dinc,
  output logic [NCH-1:0][ADDR_W-1:0] cfg_src,
  output logic [NCH-1:0][ADDR_W-1:0] cfg_dst
);

  localparam int WIN = NCH * 8;

  logic [NCH-1:0][7:0][REG_W-1:0] bank_q;
  logic [NCH-1:0]                 tc_q;
  logic [NCH-1:0]                 tc_clr;
  logic [REG_W-1:0]               stat_word;

  // Decode events, named for the checks below
  logic           in_win, is_stat, wr_chan, wr_stat, wr_other;
  logic [CW-1:0]  sel_ch;
  logic [2:0]     sel_off;

  assign in_win   = (int'(reg_addr) < WIN);
  assign is_stat  = (reg_addr == STAT_ADDR);
  assign sel_ch   = reg_addr[CW+2:3];
  assign sel_off  = reg_addr[2:0];
  assign wr_chan  = reg_wr && in_win;
  assign wr_stat  = reg_wr && is_stat;
  assign wr_other = reg_wr && !in_win && !is_stat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (wr_chan) begin
      bank_q[sel_ch][sel_off] <= reg_wdata;
    end
  end

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign tc_clr[c]        = wr_stat && reg_wdata[REG_W-1-c];
      assign stat_word[REG_W-1-c] = tc_q[c];
      assign start_req[c]     = wr_chan && (int'(sel_ch) == c) && (sel_off == OFF_CTRL)
                                && reg_wdata[CTL_EN] && (bank_q[c][OFF_COUNT][15:0] != 16'd0);
      assign cfg_count[c]     = bank_q[c][OFF_COUNT][15:0];
      assign cfg_size[c]      = bank_q[c][OFF_CTRL][CTL_SZ_HI:CTL_SZ_LO];
      assign cfg_sinc[c]      = bank_q[c][OFF_CTRL][CTL_SINC];
      assign cfg_dinc[c]      = bank_q[c][OFF_CTRL][CTL_DINC];
      assign cfg_src[c]       = {bank_q[c][OFF_SRC_H], bank_q[c][OFF_SRC_L]};
      assign cfg_dst[c]       = {bank_q[c][OFF_DST_H], bank_q[c][OFF_DST_L]};
    end
    if (NCH < REG_W) begin : g_stat_pad
      assign stat_word[REG_W-1-NCH:0] = '0;
    end
  endgenerate

  // A completion in the same cycle as a clear keeps its flag
  always_ff @(posedge clk) begin
    if (!rst_n) tc_q <= '0;
    else        tc_q <= (tc_q & ~tc_clr) | tc_set;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (in_win)       reg_rdata = bank_q[sel_ch][sel_off];
      else if (is_stat) reg_rdata = stat_word;
    end
  end

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && tc_set == '0) |=> ((stat_word & $past(reg_wdata)) == '0));

  // R2
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_other && tc_set == '0) |=> ($stable(bank_q) && $stable(tc_q)));

  // R1
  ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_chan && sel_off != OFF_CTRL) |=> $stable(cfg_size) && $stable(cfg_sinc) && $stable(cfg_dinc));

endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] start_req,
  input  logic [NCH-1:0] active_oh,
  input  logic           take,
  output logic           grant_valid,
  output logic [CW-1:0]  grant_idx,
  output logic [NCH-1:0] grant_oh
);

  logic [NCH-1:0] pending_q;
  logic [NCH-1:0] accept_new;

  // A restart on a queued or running channel is dropped
  assign accept_new = start_req & ~pending_q & ~active_oh;

  always_comb begin
    grant_oh  = '0;
    grant_idx = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (pending_q[c]) begin
        grant_oh  = '0;
        grant_oh[c] = 1'b1;
        grant_idx = CW'(c);
      end
    end
  end

  assign grant_valid = |pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending_q <= '0;
    end else begin
      pending_q <= (pending_q & ~(take ? grant_oh : '0)) | accept_new;
    end
  end

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_oh) && ((grant_oh & ~pending_q) == '0));

  // R10
  grant_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (((grant_oh - NCH'(1)) & pending_q) == '0));

  // R4
  pend_run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_q & active_oh) == '0);

endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  input  logic [CW-1:0]     grant_idx,
  input  logic [15:0]       sel_count,
  input  logic [1:0]        sel_size,
  input  logic              sel_sinc,
  input  logic              sel_dinc,
  input  logic [ADDR_W-1:0] sel_src,
  input  logic [ADDR_W-1:0] sel_dst,
  output logic              take,
  output logic [NCH-1:0]    active_oh,
  output logic [NCH-1:0]    tc_pulse,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);

  mover_state_e      state_q;
  logic [CW-1:0]     ch_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [1:0]        size_q;
  logic              sinc_q, dinc_q;
  logic [15:0]       left_q;
  logic [DATA_W-1:0] data_q;

  // Named events
  logic rd_done, elem_done, last_elem;
  assign take      = (state_q == MV_IDLE) && grant_valid;
  assign rd_done   = (state_q == MV_READ) && mem_ack;
  assign elem_done = (state_q == MV_WRITE) && mem_ack;
  assign last_elem = (left_q == 16'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      ch_q    <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      size_q  <= '0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      left_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        MV_IDLE: if (take) begin
          ch_q    <= grant_idx;
          src_q   <= sel_src;
          dst_q   <= sel_dst;
          size_q  <= sel_size;
          sinc_q  <= sel_sinc;
          dinc_q  <= sel_dinc;
          left_q  <= sel_count;
          state_q <= (sel_count != 16'd0) ? MV_READ : MV_IDLE;
        end
        MV_READ: if (rd_done) begin
          data_q  <= mem_rdata & lane_mask(size_q);
          state_q <= MV_WRITE;
        end
        MV_WRITE: if (elem_done) begin
          src_q   <= step_addr(src_q, size_q, sinc_q);
          dst_q   <= step_addr(dst_q, size_q, dinc_q);
          left_q  <= left_q - 16'd1;
          state_q <= last_elem ? MV_FINISH : MV_READ;
        end
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  always_comb begin
    active_oh = '0;
    tc_pulse  = '0;
    if (state_q != MV_IDLE)   active_oh[ch_q] = 1'b1;
    if (state_q == MV_FINISH) tc_pulse[ch_q]  = 1'b1;
  end

  assign mem_req   = (state_q == MV_READ) || (state_q == MV_WRITE);
  assign mem_we    = (state_q == MV_WRITE);
  assign mem_addr  = (state_q == MV_WRITE) ? dst_q : src_q;
  assign mem_size  = size_q;
  assign mem_wdata = data_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

  // R4
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

  // R8
  tc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tc_pulse));

  // R5
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_count == 16'd0) |=> !mem_req);

  // R7
  src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && !sinc_q) |=> $stable(src_q));

endmodule

// File: rtl/dma4_copy_engine.sv
module dma4_copy_engine
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int RAW = 6,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW-1:0]    reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_wr,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [63:0]       mem_addr,
  output logic [1:0]        mem_size,
  output logic [63:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [63:0]       mem_rdata
);

  logic [NCH-1:0]             start_req, active_oh, tc_pulse, grant_oh;
  logic [NCH-1:0][15:0]       cfg_count;
  logic [NCH-1:0][1:0]        cfg_size;
  logic [NCH-1:0]             cfg_sinc, cfg_dinc;
  logic [NCH-1:0][ADDR_W-1:0] cfg_src, cfg_dst;
  logic                       grant_valid, take;
  logic [CW-1:0]              grant_idx;

  dma4_regs #(.NCH(NCH), .RAW(RAW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .tc_set    (tc_pulse),
    .start_req (start_req),
    .cfg_count (cfg_count),
    .cfg_size  (cfg_size),
    .cfg_sinc  (cfg_sinc),
    .cfg_dinc  (cfg_dinc),
    .cfg_src   (cfg_src),
    .cfg_dst   (cfg_dst)
  );

  dma4_arb #(.NCH(NCH)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_req   (start_req),
    .active_oh   (active_oh),
    .take        (take),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .grant_oh    (grant_oh)
  );

  dma4_mover #(.NCH(NCH)) u_mover (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx),
    .sel_count   (cfg_count[grant_idx]),
    .sel_size    (cfg_size[grant_idx]),
    .sel_sinc    (cfg_sinc[grant_idx]),
    .sel_dinc    (cfg_dinc[grant_idx]),
    .sel_src     (cfg_src[grant_idx]),
    .sel_dst     (cfg_dst[grant_idx]),
    .take        (take),
    .active_oh   (active_oh),
    .tc_pulse    (tc_pulse),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_size    (mem_size),
    .mem_wdata   (mem_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata)
  );

  // R8
  tc_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tc_pulse & ~active_oh) == '0) && ((grant_oh & active_oh) == '0));

endmodule

// File: tb/dma4_copy_engine_tb.sv
module dma4_copy_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;

  always #5 clk = ~clk;

  dma4_copy_engine dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0, n_err = 0;
  int rd_cnt = 0, wr_cnt = 0, seq_err = 0, hi_err = 0;
  bit last_rd = 1'b0, done = 1'b0;
  logic [31:0] hi_s = '0, hi_d = '0;
  logic [7:0] mem [4096];
  logic [7:0] emem [4096];

  function automatic int nbytes(input logic [1:0] f);
    case (f)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  // Memory responder: acts at falling edges, random ack latency
  initial begin
    int dly = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ack = 1'b0;
      end else if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req) begin
        if (dly > 0) dly--;
        else begin
          if (!mem_we) begin
            if (mem_addr[63:32] != hi_s) hi_err++;
            if (last_rd) seq_err++;
            last_rd = 1'b1; rd_cnt++;
            for (int i = 0; i < 8; i++)
              mem_rdata[i*8 +: 8] = (i < nbytes(mem_size)) ?
                mem[mem_addr[11:0] + 12'(i)] : 8'($urandom);
          end else begin
            if (mem_addr[63:32] != hi_d) hi_err++;
            if (!last_rd) seq_err++;
            last_rd = 1'b0; wr_cnt++;
            for (int i = 0; i < nbytes(mem_size); i++)
              mem[mem_addr[11:0] + 12'(i)] = mem_wdata[i*8 +: 8];
          end
          mem_ack = 1'b1;
          dly = int'($urandom % 4);
        end
      end
    end
  end

  // Bench model of one copy on the expected memory
  task automatic model_copy(input logic [11:0] sa, input logic [11:0] da, input int n,
                            input logic [1:0] f, input bit si, input bit di);
    logic [7:0] tmp [8];
    logic [11:0] s = sa, d = da;
    for (int e = 0; e < n; e++) begin
      for (int b = 0; b < nbytes(f); b++) tmp[b] = emem[s + 12'(b)];
      for (int b = 0; b < nbytes(f); b++) emem[d + 12'(b)] = tmp[b];
      if (si) s = s + 12'(nbytes(f));
      if (di) d = d + 12'(nbytes(f));
    end
  endtask

  task automatic program_ch(input int ch, input logic [11:0] sa, input logic [11:0] da,
                            input logic [31:0] cnt_word);
    reg_write(6'(ch*8+2), hi_s);
    reg_write(6'(ch*8+3), {20'($urandom) & 20'h0, sa});
    reg_write(6'(ch*8+4), hi_d);
    reg_write(6'(ch*8+5), {20'h0, da});
    reg_write(6'(ch*8+1), cnt_word);
  endtask

  task automatic start_ch(input int ch, input logic [1:0] f, input bit si, input bit di);
    reg_write(6'(ch*8), {1'b1, 4'b0, f, di, si, 23'($urandom)});
  endtask

  task automatic wait_tc(input int ch, output bit ok);
    logic [31:0] s;
    ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      reg_read(6'h20, s);
      if (s[31-ch]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== emem[i]) bad++;
    check(bad == 0, req, 64'(bad), 64'd0);
  endtask

  task automatic run_copy(input int ch, input logic [11:0] sa, input logic [11:0] da,
                          input int n, input logic [31:0] cnt_hi, input logic [1:0] f,
                          input bit si, input bit di, input string tag);
    bit ok;
    logic [31:0] s;
    rd_cnt = 0; wr_cnt = 0; seq_err = 0; hi_err = 0; last_rd = 1'b0;
    hi_s = $urandom; hi_d = $urandom;
    program_ch(ch, sa, da, {cnt_hi[31:16], 16'(n)});
    model_copy(sa, da, n, f, si, di);
    start_ch(ch, f, si, di);
    wait_tc(ch, ok);
    check(ok, {tag, " R8 completion flag"}, 64'(ok), 64'd1);
    reg_read(6'h20, s);
    check(s == (32'h1 << (31 - ch)), {tag, " R8 status word"}, 64'(s), 64'(32'h1 << (31 - ch)));
    check(rd_cnt == n && wr_cnt == n, {tag, " R4 R5 element count"}, 64'(rd_cnt), 64'(n));
    check(seq_err == 0, {tag, " R4 read-write order"}, 64'(seq_err), 64'd0);
    check(hi_err == 0, {tag, " R7 upper address"}, 64'(hi_err), 64'd0);
    compare_mem({tag, " R6 R7 copied data"});
    reg_write(6'h20, 32'hFFFF_FFFF);
    reg_read(6'h20, s);
    check(s == 32'h0, {tag, " R9 status cleared"}, 64'(s), 64'd0);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, exp_v;
    logic [31:0] saved [8];
    bit ok;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'($urandom);
      emem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: reset state
    for (int a = 0; a <= 32; a++) begin
      reg_read(6'(a), v);
      check(v == 32'h0, "R3 register after reset", 64'(v), 64'd0);
    end
    check(mem_req == 1'b0, "R3 no request after reset", 64'(mem_req), 64'd0);

    // R1: readback of every channel register, enable kept clear
    for (int ch = 0; ch < 4; ch++) begin
      for (int o = 0; o < 8; o++) begin
        saved[o] = $urandom;
        if (o == 0) saved[o][31] = 1'b0;
        reg_write(6'(ch*8+o), saved[o]);
      end
      for (int o = 0; o < 8; o++) begin
        reg_read(6'(ch*8+o), v);
        check(v == saved[o], "R1 register readback", 64'(v), 64'(saved[o]));
      end
      // R1: low halves rewritten, upper halves kept
      for (int o = 3; o < 8; o += 2) begin
        reg_write(6'(ch*8+o), $urandom);
        reg_read(6'(ch*8+o-1), v);
        check(v == saved[o-1], "R1 upper half kept", 64'(v), 64'(saved[o-1]));
      end
    end
    check(mem_req == 1'b0, "R4 no start without enable", 64'(mem_req), 64'd0);

    // R2: unused addresses
    reg_read(6'h00, exp_v);
    for (int a = 33; a < 64; a++) begin
      reg_write(6'(a), 32'hFFFF_FFFF);
      reg_read(6'(a), v);
      check(v == 32'h0, "R2 unused address reads zero", 64'(v), 64'd0);
    end
    reg_read(6'h20, v);
    check(v == 32'h0, "R2 status untouched", 64'(v), 64'd0);
    reg_read(6'h00, v);
    check(v == exp_v, "R2 channel register untouched", 64'(v), 64'(exp_v));
    check(rd_cnt == 0 && wr_cnt == 0, "R2 no memory access", 64'(rd_cnt), 64'd0);

    // Directed copies
    run_copy(0, 12'h010, 12'h800, 1, 32'h0, 2'd0, 1'b1, 1'b1, "single byte");
    run_copy(1, 12'h100, 12'h900, 3, 32'hABCD_0000, 2'd2, 1'b1, 1'b1, "R5 upper count bits");
    run_copy(2, 12'h200, 12'hA00, 5, 32'h0, 2'd3, 1'b0, 1'b1, "R7 fixed source");
    run_copy(3, 12'h300, 12'hB00, 6, 32'h0, 2'd1, 1'b1, 1'b0, "R7 fixed destination");

    // Random copies
    for (int it = 0; it < 10; it++) begin
      run_copy(int'($urandom % 4), 12'($urandom % 1024), 12'(2048 + $urandom % 1024),
               1 + int'($urandom % 24), $urandom, 2'($urandom), 1'($urandom), 1'($urandom),
               "random R6");
    end

    // R5: zero count
    rd_cnt = 0; wr_cnt = 0;
    reg_write(6'(1*8+1), 32'hFFFF_0000);
    start_ch(1, 2'd2, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    check(rd_cnt == 0 && wr_cnt == 0, "R5 zero count no access", 64'(rd_cnt + wr_cnt), 64'd0);
    reg_read(6'h20, v);
    check(v == 32'h0, "R5 zero count no flag", 64'(v), 64'd0);

    // R10: priority behind a long copy
    rd_cnt = 0; wr_cnt = 0; last_rd = 1'b0; seq_err = 0; hi_err = 0;
    hi_s = $urandom; hi_d = $urandom;
    program_ch(3, 12'h000, 12'h800, 32'd30);
    program_ch(2, 12'h200, 12'hA00, 32'd4);
    program_ch(0, 12'h300, 12'hC00, 32'd4);
    model_copy(12'h000, 12'h800, 30, 2'd3, 1'b1, 1'b1);
    model_copy(12'h200, 12'hA00, 4, 2'd0, 1'b1, 1'b1);
    model_copy(12'h300, 12'hC00, 4, 2'd0, 1'b1, 1'b1);
    start_ch(3, 2'd3, 1'b1, 1'b1);
    start_ch(2, 2'd0, 1'b1, 1'b1);
    start_ch(0, 2'd0, 1'b1, 1'b1);
    ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      reg_read(6'h20, v);
      if (v[31] || v[29]) begin ok = 1'b1; break; end
    end
    check(ok && v[31] && !v[29], "R10 lowest channel first", 64'(v), 64'h8000_0000);
    wait_tc(2, ok);
    check(ok, "R10 second channel completes", 64'(ok), 64'd1);
    check(rd_cnt == 38 && wr_cnt == 38, "R10 total elements", 64'(rd_cnt), 64'd38);
    compare_mem("R10 data of queued channels");

    // R9: partial clear keeps other flags
    reg_write(6'h20, 32'h2000_0000);
    reg_read(6'h20, v);
    check(v == 32'h9000_0000, "R9 partial clear", 64'(v), 64'h9000_0000);
    reg_write(6'h20, 32'hF000_0000);
    reg_read(6'h20, v);
    check(v == 32'h0, "R9 full clear", 64'(v), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule